// File: doc/BRIEF.md
# Windowed Interrupt Configuration Register Bank

This block keeps the routing and priority setting of up to 128 interrupt vector slots. Software reaches it through a small register window of sixteen addresses. A group-select register names one group of eight consecutive vectors. Eight data registers then read or write the settings of the vectors in that group. Each setting has two parts: a routing bit, where 0 sends the request to the main CPU and 1 sends it to a co-processor, and a three-bit priority level. Level 0 disables the request, and levels 1 to 7 are active, with 7 the highest.

Every vector's stored routing bit and priority level drive flat output buses. A separate arbiter reads them. Some slots have fixed behaviour. The external IRQ slot has no routing bit. The spurious-interrupt slot is fixed at the CPU with level 7. The last six slots have no storage. Slots that a build-time mask marks as unused read as zero and keep no state.

Top module: `icfg_bank`

## Requirements
- R1: After reset, the group-select register reads 0x00. Every stored slot reads 0x01 (CPU, level 1) and drives route 0 and priority 1 on the output buses.
- R2: A write to address 0 stores wdata[7:4] as the group number G. A read of address 0 returns {G, 4'b0000}.
- R3: Address 8+n (n = 0..7) reaches vector slot G*8+n, which has vector offset 16*G+2n. On a stored slot the routing bit is data bit 7 and the level is data bits 2:0. Data bits 6:3 read as 0 and are not stored.
- R4: A write changes a slot on the rising clock edge at which wr_en is high. A read follows addr and the stored state within the same cycle. With wr_en low, the output buses keep their values.
- R5: route_o[i] and prio_o[3*i+2:3*i] always show the routing bit and level of slot i, as software reads them back.
- R6: Slot 121 (offset 0xF2, external IRQ) keeps its level writable, but its routing bit ignores writes and always reads and drives 0.
- R7: Slot 8 (offset 0x10, spurious) ignores writes, reads 0x07 and drives route 0 with level 7.
- R8: Slots 122 to 127 (data registers 2 to 7 while group 15 is selected) ignore writes, read 0x00 and drive route 0 with level 0.
- R9: A slot whose bit is clear in USED_MASK ignores writes, reads 0x00 and drives route 0 with level 0.
- R10: Addresses 1 to 7 read 0x00, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe for the addressed register |
| addr | input | 4 | Window address: 0 group select, 8..15 data registers |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data of the addressed register, combinational |
| route_o | output | 128 | Routing bit per slot, 1 = co-processor |
| prio_o | output | 384 | Three-bit priority level per slot, slot i at bits 3i+2:3i |

## Verification
Three kinds of sweep are used.

1. Every group is selected in turn. Each data register is written with a value derived from its group and register number, and the whole window is then read back. A fault that maps a data register to the wrong slot, or that adds the group in the wrong place, shows up because it returns a neighbour's value.
2. The same writes are compared on every clock against the full output buses. This separates storage faults from read-path faults.
3. Directed patterns probe the masked fields and slots. They write all ones to the IRQ, spurious, no-storage and unused slots, and set bits 6:3 and the low nibble of the group register. A write is also followed by a read in the same cycle, which shows whether the update happens at the clock edge or too early.

// File: rtl/icfg_pkg.sv
// Package: shared constants and the slot-kind classification for the
// windowed interrupt configuration bank. Assumes 8-bit data with the
// routing bit at bit 7 and the level at bits 2:0.
package icfg_pkg;

    localparam int DW        = 8;
    localparam int PW        = 3;
    localparam int ROUTE_BIT = 7;

    localparam logic [PW-1:0] PRIO_RST   = 3'd1;
    localparam logic [PW-1:0] PRIO_FIXED = 3'd7;

    // Behaviour class of one vector slot
    typedef enum logic [1:0] {
        K_NORM    = 2'd0,   // routing bit and level stored
        K_NOROUTE = 2'd1,   // level stored, routing forced to CPU
        K_FIXED   = 2'd2,   // read-only: CPU, top level
        K_ABSENT  = 2'd3    // no storage, reads zero
    } kind_e;

    // Classify a slot from its index and the build-time parameters
    function automatic kind_e kind_of(input int idx, input logic used,
                                      input int irq_idx, input int spur_idx,
                                      input int nostore_lo);
        if (idx == spur_idx)                return K_FIXED;
        if (!used || idx >= nostore_lo)     return K_ABSENT;
        if (idx == irq_idx)                 return K_NOROUTE;
        return K_NORM;
    endfunction

endpackage

// File: rtl/icfg_win_dec.sv
// Window decoder: splits the register window address into the
// group-select register and the eight data registers, and forms the
// slot index from the selected group. Assumes address bit NW selects the
// data registers, and that all other nonzero addresses are empty.
module icfg_win_dec #(
    parameter int NW = 3,
    parameter int GW = 4,
    localparam int AW = NW + 1,
    localparam int VW = GW + NW
) (
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [GW-1:0] grp,
    output logic          is_base,
    output logic          is_data,
    output logic          base_we,
    output logic          data_we,
    output logic [VW-1:0] vec_idx
);

    // Address classification and write steering
    always_comb begin
        is_base = (addr == '0);
        is_data = addr[AW-1];
        base_we = wr_en && is_base;
        data_we = wr_en && is_data;
        vec_idx = {grp, addr[NW-1:0]};
    end

endmodule

// File: rtl/icfg_cell.sv
// One vector slot: holds a routing bit and a priority level and applies
// the fixed rules of its kind. The kind is a parameter, so the flops of
// fixed and absent slots are left without loads and can be removed.
module icfg_cell
    import icfg_pkg::*;
#(
    parameter kind_e KIND = K_NORM
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic          w_route,
    input  logic [PW-1:0] w_prio,
    output logic          route,
    output logic [PW-1:0] prio,
    output logic [DW-1:0] rd
);

    localparam bit ROUTE_WR = (KIND == K_NORM);
    localparam bit PRIO_WR  = (KIND == K_NORM) || (KIND == K_NOROUTE);

    logic          route_q;
    logic [PW-1:0] prio_q;

    // Slot storage: reset to CPU at level 1, write only the fields the kind allows
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            route_q <= 1'b0;
            prio_q  <= PRIO_RST;
        end else if (we) begin
            if (ROUTE_WR) route_q <= w_route;
            if (PRIO_WR)  prio_q  <= w_prio;
        end
    end

    // Output and readback shaping per kind
    always_comb begin
        unique case (KIND)
            K_NORM: begin
                route = route_q;
                prio  = prio_q;
            end
            K_NOROUTE: begin
                route = 1'b0;
                prio  = prio_q;
            end
            K_FIXED: begin
                route = 1'b0;
                prio  = PRIO_FIXED;
            end
            default: begin
                route = 1'b0;
                prio  = '0;
            end
        endcase
        rd = '0;
        rd[ROUTE_BIT] = route;
        rd[PW-1:0]    = prio;
    end

endmodule

// File: rtl/icfg_bank.sv
// Windowed interrupt configuration bank: a group-select register and
// eight data registers reach the routing and priority settings of
// NUM_VEC slots. All slot settings drive flat output buses. Assumes
// DW = GW + NW + 1, so the group number sits in the top data bits and
// the readback of the group register is a vector offset.
module icfg_bank
    import icfg_pkg::*;
#(
    parameter int               NUM_VEC    = 128,
    parameter int               WIN        = 8,
    parameter logic [NUM_VEC-1:0] USED_MASK = '1,
    parameter int               IRQ_IDX    = 121,
    parameter int               SPUR_IDX   = 8,
    parameter int               NOSTORE_LO = 122,
    localparam int              NW         = $clog2(WIN),
    localparam int              GW         = $clog2(NUM_VEC / WIN),
    localparam int              AW         = NW + 1,
    localparam int              VW         = GW + NW
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [AW-1:0]         addr,
    input  logic [DW-1:0]         wdata,
    output logic [DW-1:0]         rdata,
    output logic [NUM_VEC-1:0]    route_o,
    output logic [PW*NUM_VEC-1:0] prio_o
);

    logic          is_base, is_data, base_we, data_we;
    logic [VW-1:0] vec_idx;
    logic [GW-1:0] grp_q;
    logic [DW-1:0] cell_rd [NUM_VEC];
    logic          unused_wbits;

    assign unused_wbits = ^wdata[ROUTE_BIT-1:PW];

    icfg_win_dec #(.NW(NW), .GW(GW)) u_dec (
        .wr_en   (wr_en),
        .addr    (addr),
        .grp     (grp_q),
        .is_base (is_base),
        .is_data (is_data),
        .base_we (base_we),
        .data_we (data_we),
        .vec_idx (vec_idx)
    );

    // Group-select register: keeps the group number from the top data bits
    always_ff @(posedge clk) begin
        if (!rst_n)
            grp_q <= '0;
        else if (base_we)
            grp_q <= wdata[DW-1 -: GW];
    end

    // One cell per slot, its kind fixed from the parameters
    for (genvar i = 0; i < NUM_VEC; i++) begin : g_slot
        localparam kind_e K = kind_of(i, USED_MASK[i], IRQ_IDX, SPUR_IDX, NOSTORE_LO);
        logic sel_we;
        assign sel_we = data_we && (vec_idx == VW'(i));
        icfg_cell #(.KIND(K)) u_cell (
            .clk     (clk),
            .rst_n   (rst_n),
            .we      (sel_we),
            .w_route (wdata[ROUTE_BIT]),
            .w_prio  (wdata[PW-1:0]),
            .route   (route_o[i]),
            .prio    (prio_o[PW*i +: PW]),
            .rd      (cell_rd[i])
        );
    end

    // Read mux: group register, selected slot, or zero
    always_comb begin
        if (is_base)
            rdata = {grp_q, {AW{1'b0}}};
        else if (is_data)
            rdata = cell_rd[vec_idx];
        else
            rdata = '0;
    end

endmodule

// File: rtl/icfg_bank_chk.sv
// Checker for icfg_bank: fixed-slot outputs, masked fields and the
// hold rule for the output buses. Attached by the bind below.
module icfg_bank_chk
    import icfg_pkg::*;
#(
    parameter int                 NUM_VEC    = 128,
    parameter logic [NUM_VEC-1:0] USED_MASK  = '1,
    parameter int                 IRQ_IDX    = 121,
    parameter int                 SPUR_IDX   = 8,
    parameter int                 NOSTORE_LO = 122,
    parameter int                 AW         = 4
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  wr_en,
    input logic [AW-1:0]         addr,
    input logic [DW-1:0]         rdata,
    input logic [NUM_VEC-1:0]    route_o,
    input logic [PW*NUM_VEC-1:0] prio_o
);

    // R2: group register readback has a zero low nibble
    a_r2_base_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == '0) |-> (rdata[AW-1:0] == '0));

    // R3: unstored data bits read as zero
    a_r3_mid_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
        addr[AW-1] |-> (rdata[ROUTE_BIT-1:PW] == '0));

    // R4 / R10: without a data write the output buses hold
    a_r4_hold_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en || !addr[AW-1]) |=> ($stable(route_o) && $stable(prio_o)));

    // R6: IRQ slot never routes to the co-processor
    a_r6_irq_no_route: assert property (@(posedge clk) disable iff (!rst_n)
        route_o[IRQ_IDX] == 1'b0);

    // R7: spurious slot is fixed at CPU, level 7
    a_r7_spur_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        (route_o[SPUR_IDX] == 1'b0) && (prio_o[PW*SPUR_IDX +: PW] == PRIO_FIXED));

    // R8 / R9: slots without storage drive zeros
    for (genvar i = 0; i < NUM_VEC; i++) begin : g_zero
        if (i != SPUR_IDX && (i >= NOSTORE_LO || !USED_MASK[i])) begin : g_chk
            a_r8_r9_empty_zero: assert property (@(posedge clk) disable iff (!rst_n)
                (route_o[i] == 1'b0) && (prio_o[PW*i +: PW] == '0));
        end
    end

endmodule

bind icfg_bank icfg_bank_chk #(
    .NUM_VEC    (NUM_VEC),
    .USED_MASK  (USED_MASK),
    .IRQ_IDX    (IRQ_IDX),
    .SPUR_IDX   (SPUR_IDX),
    .NOSTORE_LO (NOSTORE_LO),
    .AW         (AW)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .addr    (addr),
    .rdata   (rdata),
    .route_o (route_o),
    .prio_o  (prio_o)
);

// File: tb/icfg_bank_bench.sv
`timescale 1ns/1ps
module icfg_bank_bench;

    localparam int NV = 128;
    localparam logic [NV-1:0] MASK = ~((128'd1 << 5) | (128'd1 << 40) | (128'd1 << 77));

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [3:0]    addr = 4'd0;
    logic [7:0]    wdata = 8'd0;
    logic [7:0]    rdata;
    logic [NV-1:0] route_o;
    logic [3*NV-1:0] prio_o;

    int  total = 0;
    int  bad = 0;
    bit  live = 1'b0;
    bit  done = 1'b0;

    // Reference state
    logic       m_route [NV];
    logic [2:0] m_prio  [NV];
    logic [3:0] m_grp;

    icfg_bank #(.USED_MASK(MASK)) u_icfg_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .route_o(route_o), .prio_o(prio_o)
    );

    always #5 clk = ~clk;

    // 0 = normal, 1 = IRQ, 2 = spurious, 3 = empty
    function automatic int kind(input int i);
        if (i == 8) return 2;
        if (i >= 122 || !MASK[i]) return 3;
        if (i == 121) return 1;
        return 0;
    endfunction

    function automatic logic [7:0] m_slot(input int i);
        case (kind(i))
            0: return {m_route[i], 4'b0, m_prio[i]};
            1: return {5'b0, m_prio[i]};
            2: return 8'h07;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [7:0] m_read(input logic [3:0] a);
        if (a == 4'd0) return {m_grp, 4'b0};
        if (a[3]) return m_slot(int'(m_grp) * 8 + int'(a[2:0]));
        return 8'h00;
    endfunction

    task automatic m_reset();
        for (int i = 0; i < NV; i++) begin
            m_route[i] = 1'b0;
            m_prio[i]  = 3'd1;
        end
        m_grp = 4'd0;
    endtask

    // Reference update on the same edge as the design
    always @(posedge clk) begin
        if (!rst_n) m_reset();
        else if (wr_en) begin
            if (addr == 4'd0) m_grp = wdata[7:4];
            else if (addr[3]) begin
                int i;
                i = int'(m_grp) * 8 + int'(addr[2:0]);
                if (kind(i) == 0) begin
                    m_route[i] = wdata[7];
                    m_prio[i]  = wdata[2:0];
                end else if (kind(i) == 1) m_prio[i] = wdata[2:0];
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // R5: output buses against the reference on every clock
    always @(negedge clk) begin
        if (live && rst_n) begin
            logic [NV-1:0]   er;
            logic [3*NV-1:0] ep;
            for (int i = 0; i < NV; i++) begin
                logic [7:0] v;
                v = m_slot(i);
                er[i] = v[7];
                ep[3*i +: 3] = v[2:0];
            end
            total++;
            if (route_o !== er || prio_o !== ep) begin
                bad++;
                $display("FAIL R5 route act=%h exp=%h prio act=%h exp=%h", route_o, er, prio_o, ep);
            end
        end
    end

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input string tag, input logic [3:0] a);
        @(negedge clk);
        addr = a; wr_en = 1'b0;
        #1;
        chk(tag, {24'b0, rdata}, {24'b0, m_read(a)});
    endtask

    task automatic rd_exp(input string tag, input logic [3:0] a, input logic [7:0] e);
        @(negedge clk);
        addr = a; wr_en = 1'b0;
        #1;
        chk(tag, {24'b0, rdata}, {24'b0, e});
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog act=running exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        m_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        live = 1'b1;

        // R1: reset state
        rd_exp("R1 base", 4'd0, 8'h00);
        rd_exp("R1 slot0", 4'd8, 8'h01);
        rd_exp("R1 slot5 unused R9", 4'd13, 8'h00);
        rd_exp("R1 slot7", 4'd15, 8'h01);
        chk("R1 bus prio0", {29'b0, prio_o[2:0]}, 32'd1);

        // R2: group register keeps the high nibble only
        wr(4'd0, 8'h3C);
        rd_exp("R2 base", 4'd0, 8'h30);

        // R7: spurious slot in group 1
        wr(4'd0, 8'h10);
        wr(4'd8, 8'hFF);
        rd_exp("R7 spur", 4'd8, 8'h07);
        chk("R7 bus", {28'b0, route_o[8], prio_o[26:24]}, 32'h7);

        // R4: a read in the write cycle still shows the old value
        @(negedge clk);
        addr = 4'd9; wdata = 8'h85; wr_en = 1'b1;
        #1;
        chk("R4 before edge", {24'b0, rdata}, 32'h01);
        @(negedge clk);
        wr_en = 1'b0;
        #1;
        chk("R4 after edge", {24'b0, rdata}, 32'h85);

        // R3: mid bits dropped
        wr(4'd10, 8'h7A);
        rd_exp("R3 mid bits", 4'd10, 8'h02);

        // R10: empty addresses
        wr(4'd3, 8'h55);
        rd_exp("R10 addr3", 4'd3, 8'h00);
        rd_exp("R10 base kept", 4'd0, 8'h10);

        // R3 / R5: sweep every group, write then read back
        for (int g = 0; g < 16; g++) begin
            wr(4'd0, 8'(g << 4));
            for (int n = 0; n < 8; n++)
                wr(4'(8 + n), 8'((g * 37 + n * 11 + 5) & 255));
        end
        for (int g = 0; g < 16; g++) begin
            wr(4'd0, 8'(g << 4));
            for (int n = 0; n < 8; n++)
                rd($sformatf("R3 g%0d n%0d", g, n), 4'(8 + n));
        end

        // R6 / R8: top group
        wr(4'd0, 8'hF0);
        wr(4'd9, 8'h86);
        rd_exp("R6 irq", 4'd9, 8'h06);
        chk("R6 bus", {31'b0, route_o[121]}, 32'd0);
        wr(4'd8, 8'h83);
        rd_exp("R3 slot120", 4'd8, 8'h83);
        for (int n = 2; n < 8; n++) begin
            wr(4'(8 + n), 8'hFF);
            rd_exp("R8 empty", 4'(8 + n), 8'h00);
        end

        // R9: unused slots 40 and 77
        wr(4'd0, 8'h50);
        wr(4'd8, 8'h87);
        rd_exp("R9 slot40", 4'd8, 8'h00);
        wr(4'd0, 8'h90);
        wr(4'd13, 8'hFF);
        rd_exp("R9 slot77", 4'd13, 8'h00);
        chk("R9 bus", {28'b0, route_o[77], prio_o[233:231]}, 32'd0);

        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule